// File: doc/BRIEF.md
# Multithreaded Issue Slot Allocator

Each cycle this block fills a fixed set of issue slots from a pool of candidate instructions drawn from several hardware threads at once. Every candidate arrives with a ready bit, a thread id, an age, a branch flag and a speculative flag. The block ranks the ready candidates under a selectable priority policy. It then hands them out to slots in rank order, but a thread whose per-cycle allowance is already used up is passed over.

Slot 0 always receives the highest-ranked winner, slot 1 the next, and so on. Slots that find no eligible candidate are driven invalid. The result is registered, so the selection made from the inputs present at a rising clock edge appears on the outputs just after that edge. The candidate pool and the configuration are level inputs sampled every cycle. The issue stage downstream never stalls the allocator, so the slot outputs carry a valid flag per slot and have no ready return: nothing is held back and nothing is lost.

Top module: `slot_alloc`

## Requirements
- R1: While `rst_n` is low, every bit of `slot_vld` is 0. After reset is released, outputs stay 0 until the first clock edge at which ready candidates are present.
- R2: A candidate whose `cand_rdy` bit is 0 is never placed in a slot. Valid slots are packed from slot 0 upward, and every slot past the last winner has its `slot_vld` bit at 0.
- R3: The number of valid slots equals the smaller of the slot count (8) and the number of ready candidates that the per-thread allowance still admits.
- R4: `cfg_cap` sets the per-thread, per-cycle allowance: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives unlimited (all 8). No thread ever holds more slots than its allowance.
- R5: With `cfg_policy` = 0 (oldest first), winners go to slots in descending `cand_age` order, where a larger age means older. Equal ages go to the lower candidate index first.
- R6: With `cfg_policy` = 1 (branch first), every ready candidate with `cand_br` set ranks above every candidate without it. Inside each group the R5 order applies.
- R7: With `cfg_policy` = 2 (speculative last), every ready candidate with `cand_spec` clear ranks above every candidate with it set. Inside each group the R5 order applies.
- R8: With an allowance of 2, eight slots are filled only when at least four threads have ready candidates. With ready work from three threads, exactly six slots are filled.
- R9: `cfg_policy` = 3 ranks exactly as oldest first, and the branch and speculative flags are ignored.
- R10: The slot outputs change only at a rising clock edge. They reflect the inputs sampled at that edge, so there is one cycle of latency.
- R11: No candidate index appears in more than one valid slot in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_rdy | input | N_CAND | Per-candidate ready bit |
| cand_tid | input | N_CAND*TID_W | Thread id of each candidate, candidate i in bits [i*TID_W +: TID_W] |
| cand_age | input | N_CAND*AGE_W | Age of each candidate, larger is older |
| cand_br | input | N_CAND | Candidate is a branch |
| cand_spec | input | N_CAND | Candidate is speculative |
| cfg_policy | input | 2 | Priority policy: 0 oldest, 1 branch first, 2 speculative last, 3 as 0 |
| cfg_cap | input | 2 | Per-thread allowance code (see R4) |
| slot_vld | output | N_SLOT | Slot holds a selected candidate |
| slot_idx | output | N_SLOT*IDX_W | Candidate index for slot s in bits [s*IDX_W +: IDX_W] |

## Verification
The allocator is driven with a full pool across all four allowance codes, which separates the cap logic from the ranking. A pool holding only one or three threads shows whether slots stay empty when the allowance, rather than the supply of candidates, is the limit. Flag patterns with mixed branch and speculative bits under each policy, including the alias code, show whether the class bit is placed above age and ignored when it should be. Directed cases then probe the single rules: equal ages (tie order), a young lone branch or a lone non-speculative candidate (class beats age), a single ready candidate (packing), and the output changing only at a clock edge.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;

  typedef enum logic [1:0] {
    POL_OLDEST   = 2'd0,
    POL_BRANCH   = 2'd1,
    POL_SPECLAST = 2'd2,
    POL_ALIAS    = 2'd3
  } policy_e;

  typedef enum logic [1:0] {
    CAP_ONE  = 2'd0,
    CAP_TWO  = 2'd1,
    CAP_FOUR = 2'd2,
    CAP_ALL  = 2'd3
  } cap_e;

endpackage

// File: rtl/slot_alloc_key.sv
module slot_alloc_key
  import slot_alloc_pkg::*;
#(
  parameter int AGE_W = 4,
  localparam int KEY_W = AGE_W + 1
) (
  input  policy_e            policy,
  input  logic               is_br,
  input  logic               is_spec,
  input  logic [AGE_W-1:0]   age,
  output logic [KEY_W-1:0]   key
);

  logic cls;

  always_comb begin
    unique case (policy)
      POL_BRANCH:   cls = is_br;
      POL_SPECLAST: cls = ~is_spec;
      default:      cls = 1'b0;
    endcase
    key = {cls, age};
  end

endmodule

// File: rtl/slot_alloc_pick.sv
module slot_alloc_pick #(
  parameter int N_CAND = 16,
  parameter int N_THR  = 4,
  parameter int N_SLOT = 8,
  parameter int KEY_W  = 5,
  localparam int IDX_W = $clog2(N_CAND),
  localparam int TID_W = $clog2(N_THR),
  localparam int CNT_W = $clog2(N_SLOT + 1)
) (
  input  logic [N_CAND-1:0]             rdy,
  input  logic [N_CAND-1:0][TID_W-1:0]  tid,
  input  logic [N_CAND-1:0][KEY_W-1:0]  key,
  input  logic [CNT_W-1:0]              cap_lim,
  output logic [N_SLOT-1:0]             pick_vld,
  output logic [N_SLOT-1:0][IDX_W-1:0]  pick_idx
);

  logic [N_CAND-1:0]            taken;
  logic [N_THR-1:0][CNT_W-1:0]  thr_cnt;
  logic                         found;
  logic [KEY_W-1:0]             best_key;
  logic [IDX_W-1:0]             best;

  // Greedy fill: each slot takes the highest key still admitted by the cap.
  // Scanning upward with a strict compare keeps the lower index on ties.
  always_comb begin
    taken    = '0;
    thr_cnt  = '0;
    pick_vld = '0;
    pick_idx = '0;
    found    = 1'b0;
    best_key = '0;
    best     = '0;
    for (int s = 0; s < N_SLOT; s++) begin
      found    = 1'b0;
      best_key = '0;
      best     = '0;
      for (int j = 0; j < N_CAND; j++) begin
        if (rdy[j] && !taken[j] && (thr_cnt[tid[j]] < cap_lim) &&
            (!found || (key[j] > best_key))) begin
          found    = 1'b1;
          best_key = key[j];
          best     = IDX_W'(j);
        end
      end
      if (found) begin
        pick_vld[s]        = 1'b1;
        pick_idx[s]        = best;
        taken[best]        = 1'b1;
        thr_cnt[tid[best]] = thr_cnt[tid[best]] + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/slot_alloc.sv
module slot_alloc
  import slot_alloc_pkg::*;
#(
  parameter int N_CAND = 16,
  parameter int N_THR  = 4,
  parameter int N_SLOT = 8,
  parameter int AGE_W  = 4,
  localparam int IDX_W = $clog2(N_CAND),
  localparam int TID_W = $clog2(N_THR),
  localparam int KEY_W = AGE_W + 1,
  localparam int CNT_W = $clog2(N_SLOT + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_CAND-1:0]         cand_rdy,
  input  logic [N_CAND*TID_W-1:0]   cand_tid,
  input  logic [N_CAND*AGE_W-1:0]   cand_age,
  input  logic [N_CAND-1:0]         cand_br,
  input  logic [N_CAND-1:0]         cand_spec,
  input  logic [1:0]                cfg_policy,
  input  logic [1:0]                cfg_cap,
  output logic [N_SLOT-1:0]         slot_vld,
  output logic [N_SLOT*IDX_W-1:0]   slot_idx
);

  logic [N_CAND-1:0][TID_W-1:0]  tid_arr;
  logic [N_CAND-1:0][AGE_W-1:0]  age_arr;
  logic [N_CAND-1:0][KEY_W-1:0]  key_arr;
  logic [CNT_W-1:0]              cap_lim;
  logic [N_SLOT-1:0]             pick_vld;
  logic [N_SLOT-1:0][IDX_W-1:0]  pick_idx;
  policy_e                       policy;

  assign tid_arr = cand_tid;
  assign age_arr = cand_age;
  assign policy  = policy_e'(cfg_policy);

  always_comb begin
    unique case (cap_e'(cfg_cap))
      CAP_ONE:  cap_lim = CNT_W'(1);
      CAP_TWO:  cap_lim = CNT_W'(2);
      CAP_FOUR: cap_lim = CNT_W'(4);
      default:  cap_lim = CNT_W'(N_SLOT);
    endcase
  end

  for (genvar i = 0; i < N_CAND; i++) begin : g_key
    slot_alloc_key #(.AGE_W(AGE_W)) u_key (
      .policy  (policy),
      .is_br   (cand_br[i]),
      .is_spec (cand_spec[i]),
      .age     (age_arr[i]),
      .key     (key_arr[i])
    );
  end

  slot_alloc_pick #(
    .N_CAND (N_CAND),
    .N_THR  (N_THR),
    .N_SLOT (N_SLOT),
    .KEY_W  (KEY_W)
  ) u_pick (
    .rdy      (cand_rdy),
    .tid      (tid_arr),
    .key      (key_arr),
    .cap_lim  (cap_lim),
    .pick_vld (pick_vld),
    .pick_idx (pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld <= '0;
      slot_idx <= '0;
    end else begin
      slot_vld <= pick_vld;
      slot_idx <= pick_idx;
    end
  end

endmodule

// File: rtl/slot_alloc_chk.sv
module slot_alloc_chk #(
  parameter int N_CAND = 16,
  parameter int N_THR  = 4,
  parameter int N_SLOT = 8,
  parameter int AGE_W  = 4,
  localparam int IDX_W = $clog2(N_CAND),
  localparam int TID_W = $clog2(N_THR)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_CAND-1:0]        cand_rdy,
  input logic [N_CAND*TID_W-1:0]  cand_tid,
  input logic [1:0]               cfg_cap,
  input logic [N_SLOT-1:0]        slot_vld,
  input logic [N_SLOT*IDX_W-1:0]  slot_idx
);

  logic [N_CAND-1:0]            rdy_q;
  logic [N_CAND-1:0][TID_W-1:0] tid_q;
  logic [1:0]                   cap_q;
  logic [N_SLOT-1:0][IDX_W-1:0] idx_arr;
  logic [N_THR-1:0][31:0]       thr_use;
  int                           lim_q;

  assign idx_arr = slot_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= '0;
      tid_q <= '0;
      cap_q <= '0;
    end else begin
      rdy_q <= cand_rdy;
      tid_q <= cand_tid;
      cap_q <= cfg_cap;
    end
  end

  always_comb begin
    case (cap_q)
      2'd0:    lim_q = 1;
      2'd1:    lim_q = 2;
      2'd2:    lim_q = 4;
      default: lim_q = N_SLOT;
    endcase
    thr_use = '0;
    for (int s = 0; s < N_SLOT; s++)
      if (slot_vld[s]) thr_use[tid_q[idx_arr[s]]] = thr_use[tid_q[idx_arr[s]]] + 32'd1;
  end

  // R10: with no ready candidate sampled, the next output is empty
  a_r10_empty_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_rdy == '0) |=> (slot_vld == '0));

  // R3: unlimited cap and a pool of at least N_SLOT ready fills every slot
  a_r3_fill_all: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_cap == 2'd3) && ($countones(cand_rdy) >= N_SLOT)) |=> (&slot_vld));

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    // R2: a winner was ready when sampled
    a_r2_ready_only: assert property (@(posedge clk) disable iff (!rst_n)
      slot_vld[s] |-> rdy_q[idx_arr[s]]);
    if (s + 1 < N_SLOT) begin : g_pack
      // R2: valid slots are packed from slot 0
      a_r2_packed: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld[s+1] |-> slot_vld[s]);
    end
    for (genvar u = s + 1; u < N_SLOT; u++) begin : g_pair
      // R11: no candidate in two slots
      a_r11_unique: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld[s] && slot_vld[u]) |-> (idx_arr[s] != idx_arr[u]));
    end
  end

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    // R4: no thread exceeds its allowance
    a_r4_cap_held: assert property (@(posedge clk) disable iff (!rst_n)
      thr_use[t] <= 32'(lim_q));
  end

endmodule

bind slot_alloc slot_alloc_chk #(
  .N_CAND (N_CAND),
  .N_THR  (N_THR),
  .N_SLOT (N_SLOT),
  .AGE_W  (AGE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cand_rdy (cand_rdy),
  .cand_tid (cand_tid),
  .cfg_cap  (cfg_cap),
  .slot_vld (slot_vld),
  .slot_idx (slot_idx)
);

// File: tb/slot_alloc_bench.sv
module slot_alloc_bench;

  typedef struct packed {
    logic [15:0] rdy;
    logic [15:0] br;
    logic [15:0] spec;
    logic [1:0]  pol;
    logic [1:0]  cap;
    logic        tsel;
    logic [3:0]  cnt;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'hFFFF, 16'h0000, 16'h0000, 2'd0, 2'd3, 1'b0, 4'd8},
    '{16'hFFFF, 16'h0000, 16'h0000, 2'd0, 2'd0, 1'b0, 4'd4},
    '{16'hFFFF, 16'h0000, 16'h0000, 2'd0, 2'd1, 1'b0, 4'd8},
    '{16'h0FFF, 16'h0000, 16'h0000, 2'd0, 2'd1, 1'b1, 4'd6},
    '{16'h0000, 16'h0000, 16'h0000, 2'd0, 2'd3, 1'b0, 4'd0},
    '{16'h0013, 16'h0000, 16'h0000, 2'd0, 2'd3, 1'b0, 4'd3},
    '{16'hFFFF, 16'h0000, 16'h0000, 2'd0, 2'd2, 1'b1, 4'd8},
    '{16'h000F, 16'h0000, 16'h0000, 2'd0, 2'd2, 1'b1, 4'd4},
    '{16'h000F, 16'h0000, 16'h0000, 2'd0, 2'd0, 1'b1, 4'd1},
    '{16'hFFFF, 16'h8421, 16'h0000, 2'd1, 2'd3, 1'b0, 4'd8},
    '{16'hFFFF, 16'h0000, 16'h00FF, 2'd2, 2'd3, 1'b0, 4'd8},
    '{16'hFFFF, 16'h8421, 16'h00FF, 2'd3, 2'd1, 1'b1, 4'd8},
    '{16'h0FFF, 16'h8421, 16'h0000, 2'd1, 2'd0, 1'b0, 4'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cand_rdy = '0;
  logic [31:0] cand_tid = '0;
  logic [63:0] cand_age = '0;
  logic [15:0] cand_br = '0;
  logic [15:0] cand_spec = '0;
  logic [1:0]  cfg_policy = '0;
  logic [1:0]  cfg_cap = '0;
  logic [7:0]  slot_vld;
  logic [31:0] slot_idx;

  int tid_a [16];
  int age_a [16];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  slot_alloc u_slot_alloc (
    .clk(clk), .rst_n(rst_n), .cand_rdy(cand_rdy), .cand_tid(cand_tid),
    .cand_age(cand_age), .cand_br(cand_br), .cand_spec(cand_spec),
    .cfg_policy(cfg_policy), .cfg_cap(cfg_cap),
    .slot_vld(slot_vld), .slot_idx(slot_idx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sidx(input int s);
    return int'(slot_idx[s*4 +: 4]);
  endfunction

  task automatic pack_cands();
    for (int i = 0; i < 16; i++) begin
      cand_tid[i*2 +: 2] = 2'(tid_a[i]);
      cand_age[i*4 +: 4] = 4'(age_a[i]);
    end
  endtask

  function automatic int cls_of(input int i);
    if (cfg_policy == 2'd1) return int'(cand_br[i]);
    if (cfg_policy == 2'd2) return int'(!cand_spec[i]);
    return 0;
  endfunction

  // Rank every ready candidate, then walk the ranking honouring the allowance
  task automatic model(output logic [7:0] ev, output int ei [8]);
    int order [16];
    int tcnt [4];
    int nr = 0;
    int s = 0;
    int lim;
    ev = '0;
    for (int k = 0; k < 8; k++) ei[k] = 0;
    for (int t = 0; t < 4; t++) tcnt[t] = 0;
    case (cfg_cap)
      2'd0: lim = 1;
      2'd1: lim = 2;
      2'd2: lim = 4;
      default: lim = 8;
    endcase
    for (int i = 0; i < 16; i++) begin
      if (cand_rdy[i]) begin
        int r = 0;
        for (int k = 0; k < 16; k++) begin
          if (cand_rdy[k] && k != i) begin
            if (cls_of(k) > cls_of(i) ||
                (cls_of(k) == cls_of(i) && (age_a[k] > age_a[i] ||
                 (age_a[k] == age_a[i] && k < i))))
              r++;
          end
        end
        order[r] = i;
        nr++;
      end
    end
    for (int r = 0; r < nr; r++) begin
      int c = order[r];
      if (s < 8 && tcnt[tid_a[c]] < lim) begin
        ev[s] = 1'b1;
        ei[s] = c;
        s++;
        tcnt[tid_a[c]]++;
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] ev;
    int ei [8];
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(slot_vld == 8'h00, "R1 reset outputs", int'(slot_vld), 0);
    rst_n = 1'b1;
    step();
    chk(slot_vld == 8'h00, "R1 empty after release", int'(slot_vld), 0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < 16; i++) begin
        tid_a[i] = VECS[v].tsel ? i / 4 : i % 4;
        age_a[i] = (i * 3) & 7;
      end
      pack_cands();
      cand_rdy = VECS[v].rdy;
      cand_br = VECS[v].br;
      cand_spec = VECS[v].spec;
      cfg_policy = VECS[v].pol;
      cfg_cap = VECS[v].cap;
      step();
      model(ev, ei);
      chk($countones(slot_vld) == int'(VECS[v].cnt), "R3 R4 R8 slot count",
          $countones(slot_vld), int'(VECS[v].cnt));
      chk(slot_vld == ev, "R2 R3 valid mask", int'(slot_vld), int'(ev));
      for (int s = 0; s < 8; s++)
        if (ev[s])
          chk(sidx(s) == ei[s], "R5 R6 R7 R9 slot order", sidx(s), ei[s]);
    end

    // R10: output holds until the clock edge
    cand_rdy = 16'h0000;
    step();
    cand_rdy = 16'hFFFF;
    cfg_cap = 2'd3;
    cfg_policy = 2'd0;
    #1;
    chk(slot_vld == 8'h00, "R10 no change before edge", int'(slot_vld), 0);
    step();
    chk(slot_vld == 8'hFF, "R10 update after edge", int'(slot_vld), 255);

    // R5: equal ages go to the lower index
    for (int i = 0; i < 16; i++) begin tid_a[i] = i % 4; age_a[i] = 5; end
    pack_cands();
    cand_br = '0; cand_spec = '0;
    cand_rdy = 16'h0208;
    step();
    chk(sidx(0) == 3, "R5 tie lower index first", sidx(0), 3);
    chk(sidx(1) == 9, "R5 tie second", sidx(1), 9);
    chk(slot_vld == 8'h03, "R2 unused slots invalid", int'(slot_vld), 3);

    // R6: a young branch outranks older work
    for (int i = 0; i < 16; i++) age_a[i] = i;
    pack_cands();
    cand_rdy = 16'hFFFF;
    cand_br = 16'h0001;
    cfg_policy = 2'd1;
    step();
    chk(sidx(0) == 0, "R6 branch first", sidx(0), 0);
    chk(sidx(1) == 15, "R6 then oldest", sidx(1), 15);

    // R7: the single non-speculative candidate leads
    cand_br = 16'h0000;
    cand_spec = 16'hFFFD;
    cfg_policy = 2'd2;
    step();
    chk(sidx(0) == 1, "R7 non-speculative first", sidx(0), 1);
    chk(sidx(1) == 15, "R7 then oldest speculative", sidx(1), 15);

    // R9: alias code ignores flags
    cfg_policy = 2'd3;
    cand_br = 16'h0001;
    step();
    chk(sidx(0) == 15, "R9 alias ranks by age", sidx(0), 15);

    // R2: a lone ready candidate
    cand_rdy = 16'h0040;
    step();
    chk(slot_vld == 8'h01 && sidx(0) == 6, "R2 lone candidate", sidx(0), 6);

    // R11: full fill carries distinct indices
    cand_rdy = 16'hFFFF;
    cfg_cap = 2'd3;
    step();
    begin
      logic [15:0] seen = '0;
      int dup = 0;
      for (int s = 0; s < 8; s++) begin
        if (seen[sidx(s)]) dup++;
        seen[sidx(s)] = 1'b1;
      end
      chk(dup == 0, "R11 distinct indices", dup, 0);
    end

    // R8: two per thread, three threads supply work
    for (int i = 0; i < 16; i++) tid_a[i] = (i < 12) ? i / 4 : 3;
    pack_cands();
    cand_rdy = 16'h0FFF;
    cfg_cap = 2'd1;
    step();
    chk($countones(slot_vld) == 6, "R8 three threads fill six", $countones(slot_vld), 6);

    // R1: reset in mid-run clears outputs
    rst_n = 1'b0;
    #1;
    chk(slot_vld == 8'h00, "R1 mid-run reset", int'(slot_vld), 0);
    step();
    rst_n = 1'b1;
    step();
    finish_run();
  end

endmodule